// File: doc/BRIEF.md
# Montgomery Modulus Coefficient Calculator

This block computes the coefficient that Montgomery multiplication needs for an odd modulus `n`. The result is the value `r` with `r * n + 1 ≡ 0 (mod 2^k)`, where `k` is 32 times the number of active words. The modulus may be up to 512 bits wide. The block reads the modulus one 32-bit word per cycle from an external synchronous memory with one cycle of read latency. It derives the coefficient one bit per cycle, then writes it one word per cycle into a second external memory.

An exponentiation engine would use this block once for each new modulus. It loads the modulus memory, sets the word count and pulses `start`. When `ready` returns high, the coefficient is in the result memory and the engine can read it.

Inside, the block keeps three registers as wide as the largest operand: the negated modulus, a running product and the partial coefficient. At step `i` it tests bit `i` of the running product. When that bit is one, it sets bit `i` of the coefficient and adds the negated modulus, shifted left by `i`, to the running product. Every bit at or above `k` is cleared. Because of that masking, a short operand gives exactly the result of a computation carried out at its own width.

Top module: `mont_coeff_calc`

## Requirements
- R1: After reset, `ready` is 1 and `res_we` is 0. `res_we` is never 1 while `ready` is 1.
- R2: After a start, `op_addr` stays within 0..`last_word` while the block is busy. The word read at address `j` (returned one cycle after the address) is bits `[32j+31:32j]` of `n`, so address 0 holds the least-significant word.
- R3: For any odd `n`, the written coefficient `r` satisfies `(r * n + 1) mod 2^k = 0`, where `k = 32 * (last_word + 1)`.
- R4: The written coefficient equals the bit-loop model. Start with r = 1 and nn = -n mod 2^k. For i = 1 to k-1, if bit i of (r * nn mod 2^k) is 1, add 2^i to r.
- R5: Only result addresses 0..`last_word` are written. Result words above `last_word` keep their earlier contents.
- R6: `ready` falls in the cycle after an accepted `start`. It rises in the cycle after the last result word is written, and then stays high until the next start.
- R7: A `start` pulse while `ready` is 0 is ignored: the running computation, its word count and its result are unchanged.
- R8: Result words are written at consecutive ascending addresses starting at 0, each exactly once, with word `j` holding bits `[32j+31:32j]` of `r`.
- R9: `last_word` = 11 yields a 384-bit coefficient and `last_word` = 15 yields a 512-bit coefficient. Any value from 0 to 15 yields `32 * (last_word + 1)` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that starts a computation when `ready` is 1 |
| last_word | input | 4 | Number of active words minus one, sampled at start |
| ready | output | 1 | 1 when idle and when the result is complete |
| op_addr | output | 4 | Word address to the modulus memory |
| op_data | input | 32 | Modulus word, one cycle after `op_addr` |
| res_addr | output | 4 | Word address to the result memory |
| res_data | output | 32 | Coefficient word to write |
| res_we | output | 1 | Write enable for the result memory |

## Verification
The hardest case to reach from the ports is a second `start` that arrives mid-computation with a different word count. Ignoring it must not disturb the fetch, the bit loop or the store phase. The bench reaches this by pulsing `start` with `last_word` = 3 while a 512-bit run is in its bit loop. It then checks that `ready` stays low and that all sixteen words still match the 512-bit result. Every word count from 0 to 15 is swept with a random odd modulus. The bench also runs edge moduli, `n = 1` and `n = 2^k - 1`, so that the running product either sets every coefficient bit or sets none after bit 0.

// File: rtl/mc_pkg.sv
package mc_pkg;
    // Default geometry: 32-bit words, 16 addressable words (512 bits).
    localparam int WORD_W = 32;
    localparam int ADDR_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_NEG,
        ST_CALC,
        ST_STORE
    } mc_state_e;
endpackage

// File: rtl/mc_mask.sv
// Builds a mask that keeps the active words (0..last) and clears the rest.
module mc_mask #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 4,
    localparam int MAX_W = WORD_W * (2 ** ADDR_W)
) (
    input  logic [ADDR_W-1:0] last,
    output logic [MAX_W-1:0]  mask
);
    for (genvar w = 0; w < 2 ** ADDR_W; w++) begin : g_word
        assign mask[w*WORD_W +: WORD_W] = (ADDR_W'(w) <= last) ? '1 : '0;
    end
endmodule

// File: rtl/mc_step.sv
// One step of the bit-serial inverse computation.
module mc_step #(
    parameter int MAX_W = 512,
    parameter int BIT_W = 9
) (
    input  logic [MAX_W-1:0] acc,
    input  logic [MAX_W-1:0] nn,
    input  logic [MAX_W-1:0] r,
    input  logic [MAX_W-1:0] mask,
    input  logic [BIT_W-1:0] bitpos,
    output logic [MAX_W-1:0] acc_next,
    output logic [MAX_W-1:0] r_next
);
    logic hit;
    logic [MAX_W-1:0] onehot;

    always_comb begin
        hit      = acc[bitpos];
        onehot   = MAX_W'(1) << bitpos;
        acc_next = hit ? ((acc + (nn << bitpos)) & mask) : acc;
        r_next   = hit ? (r | onehot) : r;
    end
endmodule

// File: rtl/mont_coeff_calc.sv
// Montgomery coefficient calculator. WORD_W must be a power of two.
module mont_coeff_calc #(
    parameter int WORD_W = mc_pkg::WORD_W,
    parameter int ADDR_W = mc_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] last_word,
    output logic              ready,
    output logic [ADDR_W-1:0] op_addr,
    input  logic [WORD_W-1:0] op_data,
    output logic [ADDR_W-1:0] res_addr,
    output logic [WORD_W-1:0] res_data,
    output logic              res_we
);
    import mc_pkg::*;

    localparam int MAX_W = WORD_W * (2 ** ADDR_W);
    localparam int BIT_W = $clog2(MAX_W);
    localparam int WB    = $clog2(WORD_W);

    typedef struct packed {
        mc_state_e         st;
        logic              rdy;
        logic [ADDR_W-1:0] last;
        logic [ADDR_W-1:0] idx;
        logic [ADDR_W-1:0] prev;
        logic              have;
        logic              issued;
        logic [BIT_W-1:0]  bitpos;
        logic [MAX_W-1:0]  nn;
        logic [MAX_W-1:0]  acc;
        logic [MAX_W-1:0]  r;
    } regs_t;

    regs_t s_d, s_q;

    logic [MAX_W-1:0] mask;
    logic [MAX_W-1:0] acc_next;
    logic [MAX_W-1:0] r_next;
    logic [MAX_W-1:0] neg;
    logic [BIT_W-1:0] top_bit;

    mc_mask #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mask (
        .last (s_q.last),
        .mask (mask)
    );

    mc_step #(.MAX_W(MAX_W), .BIT_W(BIT_W)) u_step (
        .acc      (s_q.acc),
        .nn       (s_q.nn),
        .r        (s_q.r),
        .mask     (mask),
        .bitpos   (s_q.bitpos),
        .acc_next (acc_next),
        .r_next   (r_next)
    );

    // Highest bit index of the active width: 32*(last+1)-1.
    assign top_bit = BIT_W'({s_q.last, {WB{1'b1}}});
    assign neg     = (~s_q.nn + MAX_W'(1)) & mask;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st     = ST_LOAD;
                    s_d.rdy    = 1'b0;
                    s_d.last   = last_word;
                    s_d.idx    = '0;
                    s_d.have   = 1'b0;
                    s_d.issued = 1'b0;
                    s_d.nn     = '0;
                end
            end
            ST_LOAD: begin
                // Capture the word requested one cycle earlier.
                if (s_q.have) begin
                    s_d.nn[s_q.prev*WORD_W +: WORD_W] = op_data;
                end
                if (s_q.have && (s_q.prev == s_q.last)) begin
                    s_d.st   = ST_NEG;
                    s_d.have = 1'b0;
                end else if (!s_q.issued) begin
                    s_d.prev = s_q.idx;
                    s_d.have = 1'b1;
                    if (s_q.idx == s_q.last) begin
                        s_d.issued = 1'b1;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end else begin
                    s_d.have = 1'b0;
                end
            end
            ST_NEG: begin
                // Running product starts as 1 * (-n).
                s_d.nn     = neg;
                s_d.acc    = neg;
                s_d.r      = MAX_W'(1);
                s_d.bitpos = BIT_W'(1);
                s_d.st     = ST_CALC;
            end
            ST_CALC: begin
                s_d.acc = acc_next;
                s_d.r   = r_next;
                if (s_q.bitpos == top_bit) begin
                    s_d.st  = ST_STORE;
                    s_d.idx = '0;
                end else begin
                    s_d.bitpos = s_q.bitpos + 1'b1;
                end
            end
            ST_STORE: begin
                if (s_q.idx == s_q.last) begin
                    s_d.st  = ST_IDLE;
                    s_d.rdy = 1'b1;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.st  <= ST_IDLE;
            s_q.rdy <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready    = s_q.rdy;
    assign op_addr  = s_q.idx;
    assign res_we   = (s_q.st == ST_STORE);
    assign res_addr = s_q.idx;
    assign res_data = s_q.r[s_q.idx*WORD_W +: WORD_W];
endmodule

// File: rtl/mont_coeff_calc_chk.sv
// Port-level property checker, bound to the calculator.
module mont_coeff_calc_chk #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] last_word,
    input logic              ready,
    input logic [ADDR_W-1:0] op_addr,
    input logic [ADDR_W-1:0] res_addr,
    input logic              res_we
);
    logic [ADDR_W-1:0] lim;

    // Word count of the accepted start, tracked from the ports alone.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim <= '0;
        end else if (start && ready) begin
            lim <= last_word;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !res_we);

    a_r2_op_range: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (op_addr <= lim));

    a_r5_res_range: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> (res_addr <= lim));

    a_r6_ready_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> !ready);

    a_r6_ready_rises: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(res_we) && ($past(res_addr) == lim)));

    a_r7_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && start && !res_we) |=> !ready);

    a_r8_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_we) |-> (res_addr == '0));

    a_r8_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && $past(res_we)) |-> (res_addr == $past(res_addr) + 1'b1));
endmodule

bind mont_coeff_calc mont_coeff_calc_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .last_word (last_word),
    .ready     (ready),
    .op_addr   (op_addr),
    .res_addr  (res_addr),
    .res_we    (res_we)
);

// File: tb/tb_mont_coeff_calc.sv
`timescale 1ns / 1ps
module tb_mont_coeff_calc;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 4;
    localparam int NW     = 2 ** ADDR_W;
    localparam int MAX_W  = WORD_W * NW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] last_word = '0;
    logic              ready;
    logic [ADDR_W-1:0] op_addr;
    logic [WORD_W-1:0] op_data;
    logic [ADDR_W-1:0] res_addr;
    logic [WORD_W-1:0] res_data;
    logic              res_we;

    always #4 clk = ~clk;

    mont_coeff_calc #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .last_word(last_word),
        .ready(ready), .op_addr(op_addr), .op_data(op_data),
        .res_addr(res_addr), .res_data(res_data), .res_we(res_we)
    );

    logic [WORD_W-1:0] opmem  [NW];
    logic [WORD_W-1:0] resmem [NW];
    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    int exp_addr = 0;
    bit order_bad = 1'b0;
    bit addr_bad = 1'b0;
    int cur_last = 0;
    int cycles = 0;

    // Modulus memory: one cycle of read latency.
    always @(posedge clk) op_data <= opmem[op_addr];

    // Result memory and write monitor.
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (res_we) begin
            resmem[res_addr] <= res_data;
            if (int'(res_addr) != exp_addr) order_bad = 1'b1;
            exp_addr = int'(res_addr) + 1;
            wr_count = wr_count + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !ready && int'(op_addr) > cur_last) addr_bad = 1'b1;
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual hung, expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [MAX_W-1:0] act,
                         input logic [MAX_W-1:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [MAX_W-1:0] kmask(input int k);
        if (k >= MAX_W) return '1;
        return (MAX_W'(1) << k) - MAX_W'(1);
    endfunction

    // Bit-loop model with a full multiply at every step.
    function automatic logic [MAX_W-1:0] model(input logic [MAX_W-1:0] n, input int k);
        logic [MAX_W-1:0] m  = kmask(k);
        logic [MAX_W-1:0] r  = MAX_W'(1);
        logic [MAX_W-1:0] nn = (~n + MAX_W'(1)) & m;
        logic [MAX_W-1:0] t;
        for (int i = 1; i < k; i++) begin
            t = (r * nn) & m;
            if (t[i]) r = r + (MAX_W'(1) << i);
        end
        return r & m;
    endfunction

    task automatic run(input logic [MAX_W-1:0] n, input int last, input bit poke);
        logic [MAX_W-1:0] got, exp, prod, m;
        int k = WORD_W * (last + 1);
        int wait_c = 0;
        m = kmask(k);
        @(negedge clk);
        for (int w = 0; w < NW; w++) begin
            opmem[w]  = n[w*WORD_W +: WORD_W];
            resmem[w] = 32'hA5A5_0000 | w;
        end
        wr_count = 0; exp_addr = 0; order_bad = 0; addr_bad = 0; cur_last = last;
        last_word = ADDR_W'(last);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(ready == 1'b0, "R6 ready low after start", MAX_W'(ready), '0);
        if (poke) begin
            repeat (60) @(negedge clk);
            last_word = ADDR_W'(3);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(ready == 1'b0, "R7 busy start ignored", MAX_W'(ready), '0);
        end
        while (!ready && wait_c < 3000) begin
            @(negedge clk);
            wait_c++;
        end
        check(ready == 1'b1, "R6 ready high at end", MAX_W'(ready), MAX_W'(1));
        got = '0;
        for (int w = 0; w < NW; w++) got[w*WORD_W +: WORD_W] = resmem[w];
        exp = model(n, k);
        check((got & m) == exp, "R4 coefficient vs model", got & m, exp);
        prod = ((got & m) * n + MAX_W'(1)) & m;
        check(prod == '0, "R3 r*n+1 mod 2^k", prod, '0);
        for (int w = last + 1; w < NW; w++)
            check(resmem[w] == (32'hA5A5_0000 | w), "R5 inactive word kept",
                  MAX_W'(resmem[w]), MAX_W'(32'hA5A5_0000 | w));
        check(wr_count == last + 1 && !order_bad, "R8 write count and order",
              MAX_W'(wr_count), MAX_W'(last + 1));
        check(!addr_bad, "R2 operand address range", MAX_W'(addr_bad), '0);
        @(negedge clk);
        check(ready == 1'b1, "R6 ready stays high", MAX_W'(ready), MAX_W'(1));
    endtask

    function automatic logic [MAX_W-1:0] rand_odd();
        logic [MAX_W-1:0] v;
        for (int w = 0; w < NW; w++) v[w*WORD_W +: WORD_W] = $urandom;
        v[0] = 1'b1;
        return v;
    endfunction

    initial begin
        for (int w = 0; w < NW; w++) opmem[w] = '0;
        repeat (3) @(negedge clk);
        check(ready == 1'b1, "R1 reset ready", MAX_W'(ready), MAX_W'(1));
        check(res_we == 1'b0, "R1 reset no write", MAX_W'(res_we), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1 && res_we == 1'b0, "R1 idle after reset",
              MAX_W'({ready, res_we}), MAX_W'(2));
        // R9: sweep every word count.
        for (int l = 0; l < NW; l++) run(rand_odd(), l, 1'b0);
        // R9: 384-bit and 512-bit widths.
        for (int j = 0; j < 3; j++) run(rand_odd(), 11, 1'b0);
        for (int j = 0; j < 3; j++) run(rand_odd(), 15, 1'b0);
        // Edge moduli: n = 1 gives all ones, n = 2^k-1 gives 1.
        run(MAX_W'(1), 15, 1'b0);
        check(resmem[15] == 32'hFFFF_FFFF, "R3 n=1 top word", MAX_W'(resmem[15]),
              MAX_W'(32'hFFFF_FFFF));
        run(kmask(384), 11, 1'b0);
        check(resmem[0] == 32'h1 && resmem[11] == 32'h0, "R4 n=-1 gives one",
              MAX_W'(resmem[0]), MAX_W'(1));
        // R7: start pulse during a 512-bit computation.
        run(rand_odd(), 15, 1'b1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule